// File: doc/BRIEF.md
# Test-Port SRAM Access Sequencer

This block carries out single 64-bit reads and writes to an instruction memory that the ordinary load/store path cannot reach. The only way in is an indirect test port with three 32-bit registers: a command register and two data registers, one for the low half of the word and one for the high half. A requester hands over a byte address, a read/write flag and, for a write, a 64-bit word. The block then turns the address into a command word, writes the test-port registers in the required order with one wait cycle after each write, and always finishes by writing zero back to the command register so that no command is left pending. After that it raises `done` for one cycle. For a read, the 64-bit result comes from the two data registers.

The block checks the address against a memory window given by parameters. A write at or above the window end is dropped. A read is refused only when its address lies strictly above the window end, and a refused read returns zero. Refused accesses never touch the test port and finish one cycle after they are accepted. While an access is in flight `req_ready` is low. This keeps the data-register writes and the command write together as one unbroken group.

Top module: `tport_sram_seq`

## Requirements
- R1: After reset, and whenever no access is in flight, `req_ready` is 1, `done` is 0 and `tp_we` is 0.
- R2: The command word has these fields. Bit 26 is address bit 11. Bit 24 is 1. Bit 23 is address bit 15. Bits 17:16 are address bits 13:12. Bit 14 and bits 10:3 are the same address bits. Bit 2 is 1. Bit 1 is 1 for a write and 0 for a read. All other bits are 0, and address bits 2:0 are ignored.
- R3: A write performs four register writes in this order: data-low (`tp_sel`=1) with bits 31:0, data-high (`tp_sel`=2) with bits 63:32, the command (`tp_sel`=0), then command clear. The first register write comes in the cycle after acceptance, each register write is followed by one idle cycle, and `done` is high in the ninth cycle after acceptance.
- R4: A read performs two register writes: the command, then command clear, each followed by one idle cycle. `done` is high in the fifth cycle after acceptance. `rd_data` is then {data-high, data-low} as the target held them after the command write.
- R5: Every access that is carried out writes the command register with zero two cycles after its non-zero command write, and before `done`.
- R6: A write whose address is greater than or equal to WIN_BASE+WIN_SIZE makes no test-port write and raises `done` in the first cycle after acceptance.
- R7: A read whose address is strictly greater than WIN_BASE+WIN_SIZE makes no test-port write, raises `done` in the first cycle after acceptance and returns `rd_data`=0. A read at exactly WIN_BASE+WIN_SIZE is carried out.
- R8: `req_ready` is low from the cycle after acceptance up to and including the `done` cycle. A request presented during that time is ignored.
- R9: `done` lasts exactly one cycle. `rd_data` keeps its value until the next read completes. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Word to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 64 | Result of the last read |
| tp_we | output | 1 | Test-port register write strobe |
| tp_sel | output | 2 | Register select: 0 command, 1 data-low, 2 data-high |
| tp_wdata | output | 32 | Value written to the selected register |
| tp_rdata0 | input | 32 | Current data-low register content |
| tp_rdata1 | input | 32 | Current data-high register content |

## Verification
If the sequencer's state is wrong, it becomes visible at the port within one cycle. It shows up as a register strobe that should not be there or is missing, a wrong select, a skipped wait cycle, or a `done` pulse that moves away from cycle five or nine. The bench's reference model therefore compares strobes, selects, written values, `req_ready` and `done` on every clock. A command encoded wrongly, or data captured into the wrong register, shows up at the latest when the same word is read back, since the target model stores the data by the decoded command. A missing command clear is caught in the `done` cycle by inspecting the target's command register.

// File: rtl/tpa_pkg.sv
`timescale 1ns/1ps
package tpa_pkg;
  // sequencer phases
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LO,
    ST_LO_W,
    ST_HI,
    ST_HI_W,
    ST_CMD,
    ST_CMD_W,
    ST_CLR,
    ST_CLR_W,
    ST_DONE
  } st_e;

  // test-port register selects
  localparam logic [1:0] SEL_CMD = 2'd0;
  localparam logic [1:0] SEL_LO  = 2'd1;
  localparam logic [1:0] SEL_HI  = 2'd2;

  // address bits that reach the command word
  localparam int LINE_LSB = 3;
  localparam int LINE_MSB = 15;

  // command word bit positions
  localparam int CB_WAY     = 26;
  localparam int CB_ISIDE   = 24;
  localparam int CB_BANK    = 23;
  localparam int CB_SUB_LO  = 16;
  localparam int CB_ARRAY   = 2;
  localparam int CB_WRITE   = 1;
endpackage

// File: rtl/tpa_rst_sync.sv
`timescale 1ns/1ps
module tpa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= 2'b00;
    end else begin
      pipe_q <= {pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = pipe_q[1];
endmodule

// File: rtl/tpa_cmd_enc.sv
`timescale 1ns/1ps
module tpa_cmd_enc
  import tpa_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic [LINE_MSB:LINE_LSB] line_addr,
  input  logic                     is_write,
  output logic [REG_W-1:0]         cmd
);
  always_comb begin
    cmd                      = '0;
    cmd[CB_WAY]              = line_addr[11];
    cmd[CB_ISIDE]            = 1'b1;
    cmd[CB_BANK]             = line_addr[15];
    cmd[CB_SUB_LO+1:CB_SUB_LO] = line_addr[13:12];
    cmd[14]                  = line_addr[14];
    cmd[10:3]                = line_addr[10:3];
    cmd[CB_ARRAY]            = 1'b1;
    cmd[CB_WRITE]            = is_write;
  end
endmodule

// File: rtl/tpa_win_chk.sv
`timescale 1ns/1ps
module tpa_win_chk #(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h10000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  output logic              refuse
);
  localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

  logic [ADDR_W:0] addr_x;

  always_comb begin
    addr_x = {1'b0, addr};
    if (is_write) begin
      refuse = (addr_x >= WIN_END);
    end else begin
      refuse = (addr_x > WIN_END);
    end
  end
endmodule

// File: rtl/tpa_fsm.sv
`timescale 1ns/1ps
module tpa_fsm
  import tpa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic req_refuse,
  output logic accept,
  output logic ready,
  output logic done,
  output logic port_we,
  output logic [1:0] port_sel,
  output logic cap_en,
  output st_e  state
);
  st_e state_q, state_d;
  logic wr_q, wr_d;

  assign ready  = (state_q == ST_IDLE);
  assign accept = ready & req_valid;

  always_comb begin
    state_d = state_q;
    wr_d    = wr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          wr_d = req_write;
          if (req_refuse) begin
            state_d = ST_DONE;
          end else if (req_write) begin
            state_d = ST_LO;
          end else begin
            state_d = ST_CMD;
          end
        end
      end
      ST_LO:    state_d = ST_LO_W;
      ST_LO_W:  state_d = ST_HI;
      ST_HI:    state_d = ST_HI_W;
      ST_HI_W:  state_d = ST_CMD;
      ST_CMD:   state_d = ST_CMD_W;
      ST_CMD_W: state_d = ST_CLR;
      ST_CLR:   state_d = ST_CLR_W;
      ST_CLR_W: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
    end
  end

  always_comb begin
    port_we  = 1'b0;
    port_sel = SEL_CMD;
    unique case (state_q)
      ST_LO:  begin port_we = 1'b1; port_sel = SEL_LO; end
      ST_HI:  begin port_we = 1'b1; port_sel = SEL_HI; end
      ST_CMD: begin port_we = 1'b1; port_sel = SEL_CMD; end
      ST_CLR: begin port_we = 1'b1; port_sel = SEL_CMD; end
      default: begin port_we = 1'b0; port_sel = SEL_CMD; end
    endcase
  end

  assign done   = (state_q == ST_DONE);
  assign cap_en = (state_q == ST_CMD_W) & ~wr_q;
  assign state  = state_q;
endmodule

// File: rtl/tpa_rdcap.sv
`timescale 1ns/1ps
module tpa_rdcap #(
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               zero_en,
  input  logic               cap_en,
  input  logic [REG_W-1:0]   lo_in,
  input  logic [REG_W-1:0]   hi_in,
  output logic [2*REG_W-1:0] word
);
  logic [2*REG_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (zero_en) begin
      word_d = '0;
    end else if (cap_en) begin
      word_d = {hi_in, lo_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (zero_en || cap_en) begin
      word_q <= word_d;
    end
  end

  assign word = word_q;
endmodule

// File: rtl/tport_sram_seq.sv
`timescale 1ns/1ps
module tport_sram_seq
  import tpa_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                REG_W    = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h10000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [2*REG_W-1:0]   req_wdata,
  output logic                 done,
  output logic [2*REG_W-1:0]   rd_data,
  output logic                 tp_we,
  output logic [1:0]           tp_sel,
  output logic [REG_W-1:0]     tp_wdata,
  input  logic [REG_W-1:0]     tp_rdata0,
  input  logic [REG_W-1:0]     tp_rdata1
);
  localparam int DATA_W = 2 * REG_W;

  logic rst_sync_n;
  logic refuse, accept, cap_en;
  st_e  state;
  logic [LINE_MSB:LINE_LSB] line_q;
  logic                     wr_q;
  logic [DATA_W-1:0]        wdata_q;
  logic [REG_W-1:0]         cmd_word;

  tpa_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tpa_win_chk #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE)
  ) u_win (
    .addr     (req_addr),
    .is_write (req_write),
    .refuse   (refuse)
  );

  tpa_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_refuse (refuse),
    .accept     (accept),
    .ready      (req_ready),
    .done       (done),
    .port_we    (tp_we),
    .port_sel   (tp_sel),
    .cap_en     (cap_en),
    .state      (state)
  );

  // request hold registers, loaded on acceptance only
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      line_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      line_q  <= req_addr[LINE_MSB:LINE_LSB];
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  tpa_cmd_enc #(
    .REG_W (REG_W)
  ) u_enc (
    .line_addr (line_q),
    .is_write  (wr_q),
    .cmd       (cmd_word)
  );

  always_comb begin
    unique case (state)
      ST_LO:   tp_wdata = wdata_q[REG_W-1:0];
      ST_HI:   tp_wdata = wdata_q[DATA_W-1:REG_W];
      ST_CMD:  tp_wdata = cmd_word;
      default: tp_wdata = '0;
    endcase
  end

  tpa_rdcap #(
    .REG_W (REG_W)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .zero_en (accept & refuse & ~req_write),
    .cap_en  (cap_en),
    .lo_in   (tp_rdata0),
    .hi_in   (tp_rdata1),
    .word    (rd_data)
  );
endmodule

// File: rtl/tpa_seq_chk.sv
`timescale 1ns/1ps
module tpa_seq_chk
  import tpa_pkg::*;
#(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             done,
  input logic             tp_we,
  input logic [1:0]       tp_sel,
  input logic [REG_W-1:0] tp_wdata
);
  // R1: idle means quiet port and no completion
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!tp_we && !done));

  // R2: fixed command marks present on every non-zero command
  p_cmd_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_we && tp_sel == SEL_CMD && tp_wdata != '0) |-> (tp_wdata[CB_ISIDE] && tp_wdata[CB_ARRAY]));

  // R3: wait cycle after each register write
  p_wait_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tp_we |=> !tp_we);

  // R3: data-low is followed by data-high after one gap
  p_lo_then_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_we && tp_sel == SEL_LO) |=> !tp_we ##1 (tp_we && tp_sel == SEL_HI));

  // R3: data-high is followed by a write command
  p_hi_then_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_we && tp_sel == SEL_HI) |=> !tp_we ##1 (tp_we && tp_sel == SEL_CMD && tp_wdata[CB_WRITE]));

  // R5: command clear two cycles after the command
  p_clear_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_we && tp_sel == SEL_CMD && tp_wdata != '0) |=> !tp_we ##1 (tp_we && tp_sel == SEL_CMD && tp_wdata == '0));

  // R8: busy right after acceptance
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9: single-cycle completion pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind tport_sram_seq tpa_seq_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .tp_we     (tp_we),
  .tp_sel    (tp_sel),
  .tp_wdata  (tp_wdata)
);

// File: tb/tport_sram_seq_test.sv
`timescale 1ns/1ps
module tport_sram_seq_test;
  localparam longint WIN_END = 64'h10000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, done, tp_we;
  logic [31:0] req_addr, tp_wdata, tp_rdata0, tp_rdata1;
  logic [63:0] req_wdata, rd_data;
  logic [1:0]  tp_sel;

  always #5 clk = ~clk;

  tport_sram_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .tp_we(tp_we), .tp_sel(tp_sel),
    .tp_wdata(tp_wdata), .tp_rdata0(tp_rdata0), .tp_rdata1(tp_rdata1)
  );

  int checks = 0;
  int fails  = 0;

  // ---------------- test-port target model ----------------
  logic [31:0] t_lo = '0, t_hi = '0, t_cmd = '0;
  logic [63:0] tgt_mem [int];

  function automatic int cmd_to_line(logic [31:0] c);
    logic [15:0] a;
    a = '0;
    a[11] = c[26];
    a[15] = c[23];
    a[13:12] = c[17:16];
    a[14] = c[14];
    a[10:3] = c[10:3];
    return int'(a[15:3]);
  endfunction

  assign tp_rdata0 = t_lo;
  assign tp_rdata1 = t_hi;

  always @(posedge clk) begin
    if (tp_we) begin
      case (tp_sel)
        2'd1: t_lo <= tp_wdata;
        2'd2: t_hi <= tp_wdata;
        default: begin
          t_cmd <= tp_wdata;
          if (tp_wdata != 32'd0) begin
            if (tp_wdata[1]) begin
              tgt_mem[cmd_to_line(tp_wdata)] = {t_hi, t_lo};
            end else if (tgt_mem.exists(cmd_to_line(tp_wdata))) begin
              t_lo <= tgt_mem[cmd_to_line(tp_wdata)][31:0];
              t_hi <= tgt_mem[cmd_to_line(tp_wdata)][63:32];
            end else begin
              t_lo <= '0;
              t_hi <= '0;
            end
          end
        end
      endcase
    end
  end

  // ---------------- cycle reference model ----------------
  typedef struct {
    bit        we;
    bit [1:0]  sel;
    bit [31:0] wd;
    bit        dn;
    string     tag;
    bit        rd_upd;
    bit [63:0] rd_val;
    bit        chk_clr;
  } exp_t;

  exp_t        q[$];
  logic [63:0] ref_mem [int];
  logic [63:0] exp_rd = '0;
  bit          mon_en = 1'b0;

  function automatic bit [31:0] want_cmd(longint a, bit wr);
    longint v;
    v = 64'h0100_0004;
    v = v | (((a >> 11) & 1) << 26);
    v = v | (((a >> 15) & 1) << 23);
    v = v | (((a >> 12) & 3) << 16);
    v = v | (a & 64'h47F8);
    v = v | (longint'(wr) << 1);
    return v[31:0];
  endfunction

  function automatic exp_t mk(bit we, bit [1:0] sel, bit [31:0] wd, bit dn, string tag);
    exp_t e;
    e.we = we; e.sel = sel; e.wd = wd; e.dn = dn; e.tag = tag;
    e.rd_upd = 1'b0; e.rd_val = '0; e.chk_clr = 1'b0;
    return e;
  endfunction

  task automatic push_seq(bit wr, logic [31:0] a, logic [63:0] d);
    exp_t   e;
    longint ax;
    int     line;
    ax   = longint'({32'd0, a});
    line = int'(a[15:3]);
    if ((wr && ax >= WIN_END) || (!wr && ax > WIN_END)) begin
      e = mk(0, 0, 0, 1, wr ? "R6" : "R7");
      e.rd_upd = !wr;
      q.push_back(e);
    end else if (wr) begin
      q.push_back(mk(1, 1, d[31:0], 0, "R3"));
      q.push_back(mk(0, 0, 0, 0, "R3"));
      q.push_back(mk(1, 2, d[63:32], 0, "R3"));
      q.push_back(mk(0, 0, 0, 0, "R3"));
      q.push_back(mk(1, 0, want_cmd(ax, 1'b1), 0, "R2"));
      q.push_back(mk(0, 0, 0, 0, "R3"));
      q.push_back(mk(1, 0, 0, 0, "R5"));
      q.push_back(mk(0, 0, 0, 0, "R3"));
      e = mk(0, 0, 0, 1, "R3");
      e.chk_clr = 1'b1;
      q.push_back(e);
      ref_mem[line] = d;
    end else begin
      q.push_back(mk(1, 0, want_cmd(ax, 1'b0), 0, "R2"));
      q.push_back(mk(0, 0, 0, 0, "R4"));
      q.push_back(mk(1, 0, 0, 0, "R5"));
      q.push_back(mk(0, 0, 0, 0, "R4"));
      e = mk(0, 0, 0, 1, "R4");
      e.rd_upd = 1'b1;
      e.rd_val = ref_mem.exists(line) ? ref_mem[line] : 64'd0;
      e.chk_clr = 1'b1;
      q.push_back(e);
    end
  endtask

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      exp_t e;
      bit   was_empty;
      bit   ok;
      was_empty = (q.size() == 0);
      if (was_empty) e = mk(0, 0, 0, 0, "R1");
      else           e = q.pop_front();
      ok = (req_ready == was_empty) && (done == e.dn) && (tp_we == e.we);
      if (e.we) ok = ok && (tp_sel == e.sel) && (tp_wdata == e.wd);
      check(ok, e.tag, "ready/done/we/sel/wdata",
            {26'd0, req_ready, done, tp_we, tp_sel, tp_wdata},
            {26'd0, was_empty, e.dn, e.we, e.sel, e.wd});
      if (e.dn && e.rd_upd) exp_rd = e.rd_val;
      if (e.dn)       check(rd_data == exp_rd, e.tag, "rd_data at done", rd_data, exp_rd);
      else if (was_empty) check(rd_data == exp_rd, "R9", "rd_data hold", rd_data, exp_rd);
      if (e.chk_clr)  check(t_cmd == 32'd0, "R5", "command left after access", {32'd0, t_cmd}, 64'd0);
      if (was_empty && req_valid) push_seq(req_write, req_addr, req_wdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_idle();
    @(negedge clk); #1;
    while (q.size() != 0) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic req(bit wr, logic [31:0] a, logic [63:0] d, bit busy_junk);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    if (busy_junk) begin
      req_write = 1'b1; req_addr = 32'h200; req_wdata = 64'hDEAD_BEEF_0BAD_F00D;
      repeat (3) @(posedge clk);
      #2;
    end
    req_valid = 1'b0;
    wait_idle();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog: actual busy expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && !tp_we, "R1", "reset outputs", {62'd0, done, tp_we}, 64'd0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready && !done && !tp_we, "R1", "after reset",
          {61'd0, req_ready, done, tp_we}, 64'd4);
    mon_en = 1'b1;

    // writes touching way, bank, sub-bank and pass-through bits (R2, R3)
    req(1, 32'h0000_0000, 64'h1111_2222_3333_4444, 0);
    req(1, 32'h0000_0800, 64'hA5A5_0800_5A5A_0801, 0);
    req(1, 32'h0000_8000, 64'h8000_0000_0000_8000, 0);
    req(1, 32'h0000_3000, 64'h0000_3000_FFFF_0003, 0);
    req(1, 32'h0000_4000, 64'h4444_0000_0000_4444, 0);
    req(1, 32'h0000_07F8, 64'h07F8_07F8_07F8_07F8, 0);
    req(1, 32'h0000_FFF8, 64'hFEDC_BA98_7654_3210, 0);
    // reads back (R4), low address bits ignored (R2)
    req(0, 32'h0000_0805, 64'd0, 0);
    req(0, 32'h0000_8000, 64'd0, 0);
    req(0, 32'h0000_3000, 64'd0, 0);
    req(0, 32'h0000_4000, 64'd0, 0);
    req(0, 32'h0000_07F8, 64'd0, 0);
    req(0, 32'h0000_FFFF, 64'd0, 0);
    // window boundaries (R6, R7)
    req(1, 32'h0001_0000, 64'hBAD0_BAD0_BAD0_BAD0, 0);
    req(0, 32'h0000_0000, 64'd0, 0);
    req(0, 32'h0001_0000, 64'd0, 0);
    req(0, 32'h0001_0001, 64'd0, 0);
    req(1, 32'hFFFF_FFF8, 64'hBAD1_BAD1_BAD1_BAD1, 0);
    req(0, 32'hFFFF_FFF0, 64'd0, 0);
    // write leaves rd_data alone (R9), request while busy ignored (R8)
    req(0, 32'h0000_8000, 64'd0, 0);
    req(1, 32'h0000_0100, 64'h0100_0100_0100_0100, 1);
    req(0, 32'h0000_0200, 64'd0, 0);
    check(rd_data == 64'd0, "R8", "busy request must not write", rd_data, 64'd0);
    req(0, 32'h0000_0100, 64'd0, 0);
    check(rd_data == 64'h0100_0100_0100_0100, "R4", "read after busy write",
          rd_data, 64'h0100_0100_0100_0100);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule